// File: doc/BRIEF.md
# SIMT Warp Scheduler with Divergence Stack

This block holds the control state of every warp in a small SIMT core and chooses one warp per cycle for instruction fetch. Each warp has one program counter shared by all its threads, a thread mask that decides which threads write results, a lifecycle state, and a private stack of saved thread masks. The stack lets divergent paths reconverge.

Decode reports control instructions on a stall port, and the warp then stops fetching until the command port resolves it. Commands set the thread mask from a count, spawn further warps at an address, split a warp on a predicate mask, rejoin it from the stack, hold warps at a numbered barrier, or resolve a branch. Each cycle the selected warp's ID, PC and mask appear combinationally on the fetch outputs, and that warp's PC advances by 4.

Every warp runs the same state machine. Its states are IDLE (inactive), READY (eligible for fetch), WAIT (stalled on a control instruction) and BARRIER (held at a barrier). The transitions are:
- activate: IDLE to READY, on reset for warp 0 or on a spawn.
- stall: READY or BARRIER to WAIT, from the stall port.
- resolve: any active state to READY, on any command other than barrier or no-op.
- arrive: any active state to BARRIER, on a barrier command.
- release: BARRIER to READY, when the barrier count is met.
- retire: any active state to IDLE, when the thread mask becomes zero.

Top module: `simt_warp_sched`

## Requirements
- R1: After reset, only warp 0 is active. It has PC equal to RESET_PC, thread mask 0001 and state READY. The warps 1 to 3 are IDLE, and stack_err is 0.
- R2: Each cycle at most one READY warp is selected, rotating from the warp after the one selected last. fetch_valid is 0 when no warp is READY. The selected warp's PC advances by 4 at the next edge.
- R3: A stall_valid pulse for an active warp puts it in WAIT from the next cycle. It is not selected again until a command resolves it.
- R4: Command op 1 (thread mask) with count c sets the issuing warp's mask to its lowest c threads, or to all threads when c is at least the thread count. The warp becomes READY.
- R5: Command op 2 (spawn) with count c and address a activates every IDLE warp whose index is below c, except the issuer. Each such warp gets PC a and mask 0001. The issuer becomes READY.
- R6: Command op 3 (split) with mask m sets the active mask to mask AND m. It pushes mask AND NOT m onto the warp's stack, and the warp becomes READY.
- R7: Command op 4 (join) pops the top of the warp's stack into its mask, and the warp becomes READY.
- R8: The stack holds 4 entries. A split on a full stack or a join on an empty stack leaves the mask and the stack unchanged and makes the warp READY. stack_err is then high for exactly the next cycle.
- R9: Command op 5 (barrier) with barrier ID b and count c holds the warp in BARRIER. When the number of warps that have arrived at b reaches c, all of them become READY in the same edge and b is cleared.
- R10: Command op 6 (branch) sets the PC to cmd_addr when cmd_taken is 1 and otherwise keeps the sequential PC. In both cases the warp becomes READY.
- R11: Any update that leaves an active warp with an all-zero mask makes it IDLE. Commands addressed to an IDLE warp and op 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_valid | input | 1 | Decode saw a control instruction |
| stall_wid | input | 2 | Warp to stall |
| cmd_valid | input | 1 | Control command present |
| cmd_op | input | 3 | Command code (0 nop, 1 mask, 2 spawn, 3 split, 4 join, 5 barrier, 6 branch) |
| cmd_wid | input | 2 | Issuing warp |
| cmd_count | input | 3 | Thread, warp or barrier count |
| cmd_bar_id | input | 2 | Barrier number |
| cmd_addr | input | 32 | Spawn or branch target |
| cmd_taken | input | 1 | Branch outcome |
| cmd_mask | input | 4 | Split taken predicate |
| fetch_valid | output | 1 | A warp is selected |
| fetch_wid | output | 2 | Selected warp |
| fetch_pc | output | 32 | Selected warp's PC |
| fetch_tmask | output | 4 | Selected warp's thread mask |
| stack_err | output | 1 | Stack overflow or underflow in the previous cycle |

## Verification
A wrong warp state appears at the ports in the cycle the warp would next be chosen. A warp stuck in WAIT or BARRIER drops out of the rotation. A warp wrongly made READY shows up out of turn with a stale PC. A corrupted stack entry stays hidden until the matching join, when fetch_tmask takes the wrong value or the warp retires early. The bench therefore compares every output on every cycle against a behavioural model, so any difference is reported at the first fetch that exposes it.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_TMC    = 3'd1,
        OP_SPAWN  = 3'd2,
        OP_SPLIT  = 3'd3,
        OP_JOIN   = 3'd4,
        OP_BAR    = 3'd5,
        OP_BRANCH = 3'd6
    } ctl_op_e;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_READY,
        WS_WAIT,
        WS_BARRIER
    } warp_state_e;
endpackage

// File: rtl/wsched_rr_pick.sv
module wsched_rr_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic          gnt_valid,
    output logic [IW-1:0] gnt_idx
);
    // Scan from the farthest to the nearest candidate so the nearest wins.
    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int k = N; k >= 1; k--) begin
            if (req[(int'(last) + k) % N]) begin
                gnt_valid = 1'b1;
                gnt_idx   = IW'((int'(last) + k) % N);
            end
        end
    end
endmodule

// File: rtl/wsched_div_stack.sv
module wsched_div_stack #(
    parameter int DEPTH = 4,
    parameter int NT    = 4,
    localparam int PW   = $clog2(DEPTH + 1),
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [NT-1:0] push_mask,
    output logic [NT-1:0] top_mask,
    output logic          full,
    output logic          empty
);
    logic [NT-1:0] entry_q [DEPTH];
    logic [PW-1:0] ptr_q;
    logic [PW-1:0] top_ptr;

    assign full     = (ptr_q == PW'(DEPTH));
    assign empty    = (ptr_q == '0);
    assign top_ptr  = ptr_q - PW'(1);
    assign top_mask = entry_q[top_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) entry_q[i] <= '0;
        end else if (push && !full) begin
            entry_q[ptr_q[AW-1:0]] <= push_mask;
            ptr_q <= ptr_q + PW'(1);
        end else if (pop && !empty) begin
            ptr_q <= top_ptr;
        end
    end
endmodule

// File: rtl/wsched_barrier.sv
module wsched_barrier #(
    parameter int NW = 4,
    parameter int NB = 4,
    parameter int CW = 3,
    localparam int WW = (NW > 1) ? $clog2(NW) : 1,
    localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arrive,
    input  logic [WW-1:0] arrive_wid,
    input  logic [BW-1:0] bar_id,
    input  logic [CW-1:0] bar_count,
    output logic [NW-1:0] release_mask
);
    logic [NW-1:0] arrived_q [NB];
    logic [NW-1:0] arrived_d [NB];
    logic [NW-1:0] merged;

    function automatic int popcnt(input logic [NW-1:0] v);
        int n = 0;
        for (int i = 0; i < NW; i++) n += int'(v[i]);
        return n;
    endfunction

    always_comb begin
        release_mask = '0;
        merged       = arrived_q[bar_id] | (NW'(1) << arrive_wid);
        for (int b = 0; b < NB; b++) arrived_d[b] = arrived_q[b];
        if (arrive) begin
            if (popcnt(merged) >= int'(bar_count)) begin
                release_mask      = merged;
                arrived_d[bar_id] = '0;
            end else begin
                arrived_d[bar_id] = merged;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int b = 0; b < NB; b++) begin
            if (!rst_n) arrived_q[b] <= '0;
            else        arrived_q[b] <= arrived_d[b];
        end
    end
endmodule

// File: rtl/simt_warp_sched.sv
module simt_warp_sched
    import wsched_pkg::*;
#(
    parameter int          NUM_WARPS    = 4,
    parameter int          NUM_THREADS  = 4,
    parameter int          STACK_DEPTH  = 4,
    parameter int          NUM_BARRIERS = 4,
    parameter int          PC_W         = 32,
    parameter logic [31:0] RESET_PC     = 32'h8000_0000,
    localparam int WW = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int BW = (NUM_BARRIERS > 1) ? $clog2(NUM_BARRIERS) : 1,
    localparam int CW = $clog2(((NUM_WARPS > NUM_THREADS) ? NUM_WARPS : NUM_THREADS) + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   stall_valid,
    input  logic [WW-1:0]          stall_wid,
    input  logic                   cmd_valid,
    input  logic [2:0]             cmd_op,
    input  logic [WW-1:0]          cmd_wid,
    input  logic [CW-1:0]          cmd_count,
    input  logic [BW-1:0]          cmd_bar_id,
    input  logic [PC_W-1:0]        cmd_addr,
    input  logic                   cmd_taken,
    input  logic [NUM_THREADS-1:0] cmd_mask,
    output logic                   fetch_valid,
    output logic [WW-1:0]          fetch_wid,
    output logic [PC_W-1:0]        fetch_pc,
    output logic [NUM_THREADS-1:0] fetch_tmask,
    output logic                   stack_err
);
    localparam int NW = NUM_WARPS;
    localparam int NT = NUM_THREADS;

    warp_state_e      st_q   [NW];
    warp_state_e      st_d   [NW];
    logic [PC_W-1:0]  pc_q   [NW];
    logic [PC_W-1:0]  pc_d   [NW];
    logic [NT-1:0]    mask_q [NW];
    logic [NT-1:0]    mask_d [NW];
    logic [WW-1:0]    last_q;

    ctl_op_e          op;
    logic [NW-1:0]    ready_w;
    logic             gnt_valid;
    logic [WW-1:0]    gnt_idx;
    logic [NT-1:0]    tmc_mask;
    logic             issuer_live;
    logic [NW-1:0]    bar_release;
    logic [NW-1:0]    stk_push, stk_pop, stk_full, stk_empty;
    logic [NT-1:0]    stk_top [NW];
    logic             err_d, err_q;

    assign op          = ctl_op_e'(cmd_op);
    assign issuer_live = cmd_valid && (st_q[cmd_wid] != WS_IDLE);

    // Selection among READY warps
    for (genvar w = 0; w < NW; w++) begin : g_ready
        assign ready_w[w] = (st_q[w] == WS_READY);
    end

    wsched_rr_pick #(.N(NW)) u_pick (
        .req       (ready_w),
        .last      (last_q),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    assign fetch_valid = gnt_valid;
    assign fetch_wid   = gnt_idx;
    assign fetch_pc    = pc_q[gnt_idx];
    assign fetch_tmask = mask_q[gnt_idx];
    assign stack_err   = err_q;

    // Thread mask from a count
    always_comb begin
        for (int t = 0; t < NT; t++) tmc_mask[t] = (t < int'(cmd_count));
    end

    // Reconvergence stacks, one per warp
    for (genvar w = 0; w < NW; w++) begin : g_stack
        assign stk_push[w] = issuer_live && (cmd_wid == WW'(w)) && (op == OP_SPLIT);
        assign stk_pop[w]  = issuer_live && (cmd_wid == WW'(w)) && (op == OP_JOIN);
        wsched_div_stack #(.DEPTH(STACK_DEPTH), .NT(NT)) u_stack (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (stk_push[w]),
            .pop       (stk_pop[w]),
            .push_mask (mask_q[w] & ~cmd_mask),
            .top_mask  (stk_top[w]),
            .full      (stk_full[w]),
            .empty     (stk_empty[w])
        );
    end

    wsched_barrier #(.NW(NW), .NB(NUM_BARRIERS), .CW(CW)) u_bar (
        .clk          (clk),
        .rst_n        (rst_n),
        .arrive       (issuer_live && (op == OP_BAR)),
        .arrive_wid   (cmd_wid),
        .bar_id       (cmd_bar_id),
        .bar_count    (cmd_count),
        .release_mask (bar_release)
    );

    assign err_d = issuer_live &&
                   (((op == OP_SPLIT) && stk_full[cmd_wid]) ||
                    ((op == OP_JOIN)  && stk_empty[cmd_wid]));

    // Per-warp state machine: next-state process
    always_comb begin
        for (int w = 0; w < NW; w++) begin
            st_d[w]   = st_q[w];
            pc_d[w]   = pc_q[w];
            mask_d[w] = mask_q[w];

            if (gnt_valid && gnt_idx == WW'(w))
                pc_d[w] = pc_q[w] + PC_W'(4);

            // stall transition
            if (stall_valid && stall_wid == WW'(w) && st_q[w] != WS_IDLE)
                st_d[w] = WS_WAIT;

            // command transitions: resolve / arrive
            if (issuer_live && cmd_wid == WW'(w)) begin
                unique case (op)
                    OP_TMC: begin
                        mask_d[w] = tmc_mask;
                        st_d[w]   = WS_READY;
                    end
                    OP_SPAWN: st_d[w] = WS_READY;
                    OP_SPLIT: begin
                        if (!stk_full[w]) mask_d[w] = mask_q[w] & cmd_mask;
                        st_d[w] = WS_READY;
                    end
                    OP_JOIN: begin
                        if (!stk_empty[w]) mask_d[w] = stk_top[w];
                        st_d[w] = WS_READY;
                    end
                    OP_BAR: st_d[w] = WS_BARRIER;
                    OP_BRANCH: begin
                        if (cmd_taken) pc_d[w] = cmd_addr;
                        st_d[w] = WS_READY;
                    end
                    default: ;
                endcase
            end

            // activate transition
            if (issuer_live && op == OP_SPAWN && st_q[w] == WS_IDLE &&
                w < int'(cmd_count) && cmd_wid != WW'(w)) begin
                st_d[w]   = WS_READY;
                pc_d[w]   = cmd_addr;
                mask_d[w] = NT'(1);
            end

            // release transition
            if (bar_release[w]) st_d[w] = WS_READY;

            // retire transition
            if (st_d[w] != WS_IDLE && mask_d[w] == '0) st_d[w] = WS_IDLE;
        end
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NW; w++) begin
                st_q[w]   <= (w == 0) ? WS_READY : WS_IDLE;
                pc_q[w]   <= (w == 0) ? PC_W'(RESET_PC) : '0;
                mask_q[w] <= (w == 0) ? NT'(1) : '0;
            end
            last_q <= WW'(NW - 1);
            err_q  <= 1'b0;
        end else begin
            for (int w = 0; w < NW; w++) begin
                st_q[w]   <= st_d[w];
                pc_q[w]   <= pc_d[w];
                mask_q[w] <= mask_d[w];
            end
            if (gnt_valid) last_q <= gnt_idx;
            err_q <= err_d;
        end
    end
endmodule

// File: rtl/simt_warp_sched_chk.sv
module simt_warp_sched_chk #(
    parameter int NW = 4,
    parameter int NT = 4,
    parameter int WW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stall_valid,
    input logic [WW-1:0] stall_wid,
    input logic          cmd_valid,
    input logic [2:0]    cmd_op,
    input logic [WW-1:0] cmd_wid,
    input logic          fetch_valid,
    input logic [WW-1:0] fetch_wid,
    input logic [NT-1:0] fetch_tmask,
    input logic          stack_err,
    input logic [NW-1:0] ready_w
);
    a_r1_reset_warp0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (fetch_valid && fetch_wid == '0 && fetch_tmask == NT'(1)));

    a_r2_rotates: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && $past(fetch_valid) && $countones(ready_w) > 1)
        |-> (fetch_wid != $past(fetch_wid)));

    a_r3_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_valid && !(cmd_valid && (cmd_wid == stall_wid || cmd_op == 3'd5)))
        |=> !(fetch_valid && fetch_wid == $past(stall_wid)));

    a_r8_err_source: assert property (@(posedge clk) disable iff (!rst_n)
        stack_err |-> ($past(cmd_valid) && ($past(cmd_op) == 3'd3 || $past(cmd_op) == 3'd4)));

    a_r11_live_mask: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> (fetch_tmask != '0));
endmodule

bind simt_warp_sched simt_warp_sched_chk #(.NW(NUM_WARPS), .NT(NUM_THREADS), .WW(WW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stall_valid (stall_valid),
    .stall_wid   (stall_wid),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_wid     (cmd_wid),
    .fetch_valid (fetch_valid),
    .fetch_wid   (fetch_wid),
    .fetch_tmask (fetch_tmask),
    .stack_err   (stack_err),
    .ready_w     (ready_w)
);

// File: tb/simt_warp_sched_tb.sv
module simt_warp_sched_tb;
    localparam logic [31:0] RPC = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall_valid = 1'b0;
    logic [1:0]  stall_wid = '0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [1:0]  cmd_wid = '0;
    logic [2:0]  cmd_count = '0;
    logic [1:0]  cmd_bar_id = '0;
    logic [31:0] cmd_addr = '0;
    logic        cmd_taken = 1'b0;
    logic [3:0]  cmd_mask = '0;
    logic        fetch_valid;
    logic [1:0]  fetch_wid;
    logic [31:0] fetch_pc;
    logic [3:0]  fetch_tmask;
    logic        stack_err;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    simt_warp_sched u_dut (.*);

    // Behavioural model: 0 idle, 1 ready, 2 wait, 3 barrier
    int          m_st [4];
    logic [31:0] m_pc [4];
    logic [3:0]  m_mask [4];
    logic [3:0]  m_stk [4][$];
    logic [3:0]  m_bar [4];
    int          m_last;
    bit          m_err;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic int m_pick();
        for (int k = 1; k <= 4; k++)
            if (m_st[(m_last + k) % 4] == 1) return (m_last + k) % 4;
        return -1;
    endfunction

    task automatic m_reset();
        for (int w = 0; w < 4; w++) begin
            m_st[w] = (w == 0) ? 1 : 0;
            m_pc[w] = (w == 0) ? RPC : 0;
            m_mask[w] = (w == 0) ? 4'b0001 : 4'b0000;
            m_stk[w].delete();
            m_bar[w] = 0;
        end
        m_last = 3;
        m_err = 0;
    endtask

    task automatic m_update();
        int os [4];
        int p;
        int cnt;
        int rel;
        for (int w = 0; w < 4; w++) os[w] = m_st[w];
        p = m_pick();
        m_err = 0;
        rel = 0;
        if (p >= 0) begin
            m_pc[p] = m_pc[p] + 4;
            m_last = p;
        end
        if (stall_valid && os[stall_wid] != 0) m_st[stall_wid] = 2;
        if (cmd_valid && os[cmd_wid] != 0) begin
            case (cmd_op)
                1: begin
                    m_mask[cmd_wid] = (cmd_count >= 4) ? 4'hF : 4'((1 << cmd_count) - 1);
                    m_st[cmd_wid] = 1;
                end
                2: begin
                    m_st[cmd_wid] = 1;
                    for (int w = 0; w < 4; w++)
                        if (os[w] == 0 && w < cmd_count && w != cmd_wid) begin
                            m_st[w] = 1; m_pc[w] = cmd_addr; m_mask[w] = 4'b0001;
                        end
                end
                3: begin
                    if (m_stk[cmd_wid].size() < 4) begin
                        m_stk[cmd_wid].push_back(m_mask[cmd_wid] & ~cmd_mask);
                        m_mask[cmd_wid] = m_mask[cmd_wid] & cmd_mask;
                    end else m_err = 1;
                    m_st[cmd_wid] = 1;
                end
                4: begin
                    if (m_stk[cmd_wid].size() > 0) m_mask[cmd_wid] = m_stk[cmd_wid].pop_back();
                    else m_err = 1;
                    m_st[cmd_wid] = 1;
                end
                5: begin
                    m_st[cmd_wid] = 3;
                    m_bar[cmd_bar_id][cmd_wid] = 1'b1;
                    cnt = $countones(m_bar[cmd_bar_id]);
                    if (cnt >= cmd_count) begin
                        rel = int'(m_bar[cmd_bar_id]);
                        m_bar[cmd_bar_id] = 0;
                    end
                end
                6: begin
                    if (cmd_taken) m_pc[cmd_wid] = cmd_addr;
                    m_st[cmd_wid] = 1;
                end
                default: ;
            endcase
        end
        for (int w = 0; w < 4; w++) begin
            if (rel[w]) m_st[w] = 1;
            if (m_st[w] != 0 && m_mask[w] == 0) m_st[w] = 0;
        end
    endtask

    task automatic compare();
        int p = m_pick();
        chk({cur_req, " fetch_valid"}, 64'(fetch_valid), 64'(p >= 0));
        if (p >= 0) begin
            chk({cur_req, " fetch_wid"}, 64'(fetch_wid), 64'(p));
            chk({cur_req, " fetch_pc"}, 64'(fetch_pc), 64'(m_pc[p]));
            chk({cur_req, " fetch_tmask"}, 64'(fetch_tmask), 64'(m_mask[p]));
        end
        chk({cur_req, " stack_err"}, 64'(stack_err), 64'(m_err));
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst_n) m_update(); else m_reset();
        @(negedge clk);
        stall_valid = 0;
        cmd_valid = 0;
        #1 compare();
    endtask

    task automatic stall(input int w);
        stall_valid = 1; stall_wid = 2'(w);
        tick();
    endtask

    task automatic cmd(input int op, input int w, input int c, input int b,
                       input logic [31:0] a, input bit tk, input logic [3:0] m);
        cmd_valid = 1; cmd_op = 3'(op); cmd_wid = 2'(w); cmd_count = 3'(c);
        cmd_bar_id = 2'(b); cmd_addr = a; cmd_taken = tk; cmd_mask = m;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) tick();
        @(negedge clk);
        rst_n = 1;
        // R1: reset state visible on the first cycle
        #1;
        cur_req = "R1";
        chk("R1 wid", 64'(fetch_wid), 0);
        chk("R1 pc", 64'(fetch_pc), 64'(RPC));
        chk("R1 mask", 64'(fetch_tmask), 1);
        compare();
        // R2: warp 0 alone, PC steps by 4
        cur_req = "R2";
        repeat (3) tick();
        // R3 then R5: stall, then spawn all four warps
        cur_req = "R3";
        stall(0);
        repeat (2) tick();
        cur_req = "R5";
        cmd(2, 0, 4, 0, 32'h100, 0, 0);
        cur_req = "R2";
        repeat (6) tick();
        // R4: thread mask counts, full and clamp
        cur_req = "R4";
        stall(1); cmd(1, 1, 4, 0, 0, 0, 0);
        stall(3); cmd(1, 3, 7, 0, 0, 0, 0);
        stall(0); cmd(1, 0, 2, 0, 0, 0, 0);
        repeat (4) tick();
        // R11: zero count retires warp 2; command to idle warp ignored
        cur_req = "R11";
        stall(2); cmd(1, 2, 0, 0, 0, 0, 0);
        cmd(6, 2, 0, 0, 32'h500, 1, 0);
        repeat (4) tick();
        // R6 and R7: split then join
        cur_req = "R6";
        stall(1); cmd(3, 1, 0, 0, 0, 0, 4'b0101);
        repeat (3) tick();
        cur_req = "R7";
        stall(1); cmd(4, 1, 0, 0, 0, 0, 0);
        repeat (3) tick();
        // R8: underflow, then overflow after four pushes
        cur_req = "R8";
        cmd(4, 1, 0, 0, 0, 0, 0);
        tick();
        for (int i = 0; i < 5; i++) cmd(3, 3, 0, 0, 0, 0, 4'b1111);
        tick();
        for (int i = 0; i < 4; i++) cmd(4, 3, 0, 0, 0, 0, 0);
        repeat (2) tick();
        // R9: barrier of two, then barrier of three
        cur_req = "R9";
        cmd(1, 3, 4, 0, 0, 0, 0);
        cmd(5, 0, 2, 1, 0, 0, 0);
        repeat (3) tick();
        cmd(5, 1, 2, 1, 0, 0, 0);
        repeat (3) tick();
        cmd(5, 0, 3, 2, 0, 0, 0);
        cmd(5, 1, 3, 2, 0, 0, 0);
        repeat (2) tick();
        cmd(5, 3, 3, 2, 0, 0, 0);
        repeat (3) tick();
        // R10: branch taken and not taken
        cur_req = "R10";
        stall(1); cmd(6, 1, 0, 0, 32'h2000, 1, 0);
        stall(0); cmd(6, 0, 0, 0, 32'h3000, 0, 0);
        repeat (4) tick();
        // Mixed traffic against the model
        cur_req = "R2";
        for (int i = 0; i < 3000; i++) begin
            int r = int'($urandom_range(0, 9));
            if (r < 2) begin
                stall_valid = 1; stall_wid = 2'($urandom_range(0, 3));
            end
            if (r >= 3) begin
                cmd_valid = 1;
                cmd_op = 3'($urandom_range(0, 6));
                cmd_wid = 2'($urandom_range(0, 3));
                cmd_count = 3'($urandom_range(0, 4));
                cmd_bar_id = 2'($urandom_range(0, 3));
                cmd_addr = {$urandom_range(0, 255), 2'b00};
                cmd_taken = 1'($urandom_range(0, 1));
                cmd_mask = 4'($urandom_range(0, 15));
            end
            tick();
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule